// File: doc/BRIEF.md
# Serial Audio Link Output-Frame Deframer

This block sits on the codec side of a five-wire serial audio link. It receives the controller's outgoing stream and turns it into parallel events. The controller marks each frame with a sync pulse. A frame is a 16-bit tag slot followed by twelve 20-bit slots, sent MSB first.

The block samples sync and serial data on the falling edge of the bit clock and locks onto the frame boundary. It then decodes the tag slot, where one bit says whether the frame holds anything and twelve bits say which slots carry data. From the slots it recovers register read and write commands and four playback sample streams: front left and right, and surround left and right. Each result comes out as a one-cycle strobe with its payload. The register file, the converters and the volume logic use these strobes; they are not part of this block.

Top module: `aclink_out_deframer`

## Requirements
- R1: While rst_n is low, all strobes are 0 and slot_tags_o, cmd_idx_o, cmd_wdata_o, cmd_rd_o, smp_chan_o and smp_data_o are 0.
- R2: Alignment. A falling-edge sample where sync_i is 1 and the previous sample was 0 marks the frame start. The next sample is frame bit 0, the MSB of the tag slot. No output is produced before the first such start. A new start in the middle of a frame restarts the frame at that point.
- R3: Tag-slot bit 15 (frame bit 0) is the frame-valid flag. Tag-slot bit 14−k (frame bit 1+k) is the tag of slot k+1. In a valid frame, tag_stb_o pulses for one cycle in the cycle after the last tag-slot bit is sampled. At that pulse, slot_tags_o[k] equals the tag of slot k+1. slot_tags_o holds its value between pulses.
- R4: When the frame-valid flag is 0, the frame produces no strobes at all, and slot_tags_o keeps its previous value.
- R5: Write command. Slot 1 bit 19 is 0 for a write and 1 for a read. Slot 1 bits 18..12 are the register index. Slot 2 bits 19..4 are the write data. When the slot 1 and slot 2 tags are both set and bit 19 is 0, cmd_stb_o pulses with cmd_rd_o=0, the index and the data. The pulse comes in the cycle after the last slot-2 bit is sampled.
- R6: Read command. When the slot 1 tag is set and slot 1 bit 19 is 1, cmd_stb_o pulses at the same point with cmd_rd_o=1, the index, and cmd_wdata_o=0. The slot 2 tag and the slot 2 contents do not matter.
- R7: A write whose slot 2 tag is clear produces no command.
- R8: Samples. The 20-bit slots 3, 4, 7 and 8 carry front left, front right, surround left and surround right. On smp_chan_o these are codes 0, 1, 2 and 3. A tagged sample slot pulses smp_stb_o with its code and all 20 bits in the cycle after its last bit is sampled.
- R9: A sample slot whose tag is clear produces no sample strobe.
- R10: Slots 5, 6, 9, 10, 11 and 12 never produce an output, even when they are tagged and hold data.
- R11: Every strobe lasts exactly one bit-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; inputs sampled and state updated on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller |
| sdata_i | input | 1 | Serial output stream from the controller |
| tag_stb_o | output | 1 | Pulse: a valid frame's tags were decoded |
| slot_tags_o | output | NUM_SLOTS | Tags of slots 1..NUM_SLOTS from the last valid frame |
| cmd_stb_o | output | 1 | Pulse: register command available |
| cmd_rd_o | output | 1 | 1 = read command, 0 = write command |
| cmd_idx_o | output | IDX_W | Register index |
| cmd_wdata_o | output | DATA_W | Write data (0 for reads) |
| smp_stb_o | output | 1 | Pulse: playback sample available |
| smp_chan_o | output | 2 | Channel code: 0 front L, 1 front R, 2 surround L, 3 surround R |
| smp_data_o | output | SAMPLE_W | Sample, MSB first as received |

## Verification
The bench builds the block with its default parameters: a 16-bit tag slot and twelve 20-bit slots, giving a 256-bit frame. With these values every slot boundary sits at a fixed bit number (15, 55, 75, 95, 155, 175), so each strobe is checked against an exact position in the frame. Frames with full tags, a cleared frame-valid flag, partial tags, reads carrying non-zero slot-2 data, and a frame cut short by a new sync bring the gating rules and realignment within reach. A run of data with sync held low shows that nothing is emitted before alignment.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;
    // slot numbers the decoder reacts to (behaviour depends on them)
    localparam int CMD_ADDR_SLOT = 1;
    localparam int CMD_DATA_SLOT = 2;
    localparam int NUM_PCM_CH    = 4;
    localparam int CHAN_W        = 2;
    // channel code c is carried in slot PCM_SLOT[c]
    localparam int PCM_SLOT [NUM_PCM_CH] = '{3, 4, 7, 8};
endpackage

// File: rtl/ac_frame_align.sv
module ac_frame_align #(
    parameter int TAG_W      = 16,
    parameter int SLOT_W     = 20,
    parameter int NUM_SLOTS  = 12,
    parameter int SLOT_IDX_W = $clog2(NUM_SLOTS + 1),
    parameter int BIT_W      = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
    input  logic                  bit_clk,
    input  logic                  rst_n,
    input  logic                  sync_i,
    output logic                  active_o,
    output logic                  last_o,
    output logic [SLOT_IDX_W-1:0] slot_o
);
    localparam logic [BIT_W-1:0]      TAG_LAST  = BIT_W'(TAG_W - 1);
    localparam logic [BIT_W-1:0]      SLOT_LAST = BIT_W'(SLOT_W - 1);
    localparam logic [SLOT_IDX_W-1:0] FINAL_SL  = SLOT_IDX_W'(NUM_SLOTS);

    typedef struct packed {
        logic                  sync;
        logic                  active;
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_W-1:0]      bitn;
    } align_t;

    align_t q, d;
    logic   start_c, last_c;

    always_comb begin
        d       = q;
        d.sync  = sync_i;
        start_c = sync_i & ~q.sync;
        last_c  = q.active &
                  ((q.slot == '0) ? (q.bitn == TAG_LAST) : (q.bitn == SLOT_LAST));
        if (start_c) begin
            d.active = 1'b1;
            d.slot   = '0;
            d.bitn   = '0;
        end else if (q.active) begin
            if (last_c) begin
                d.bitn = '0;
                if (q.slot == FINAL_SL) begin
                    d.active = 1'b0;
                    d.slot   = '0;
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end else begin
                d.bitn = q.bitn + 1'b1;
            end
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o = q.active;
    assign last_o   = last_c;
    assign slot_o   = q.slot;
endmodule

// File: rtl/ac_slot_shift.sv
module ac_slot_shift #(
    parameter int W = 20
) (
    input  logic         bit_clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         sdi,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_q, sh_d;

    always_comb begin
        word_o = {sh_q[W-2:0], sdi};
        sh_d   = en_i ? word_o : sh_q;
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/aclink_out_deframer.sv
module aclink_out_deframer
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    parameter int IDX_W     = 7,
    parameter int DATA_W    = 16,
    parameter int SAMPLE_W  = 20
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 sync_i,
    input  logic                 sdata_i,
    output logic                 tag_stb_o,
    output logic [NUM_SLOTS-1:0] slot_tags_o,
    output logic                 cmd_stb_o,
    output logic                 cmd_rd_o,
    output logic [IDX_W-1:0]     cmd_idx_o,
    output logic [DATA_W-1:0]    cmd_wdata_o,
    output logic                 smp_stb_o,
    output logic [1:0]           smp_chan_o,
    output logic [SAMPLE_W-1:0]  smp_data_o
);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);

    logic                  active, last;
    logic [SLOT_IDX_W-1:0] slot;
    logic [SLOT_W-1:0]     word;

    ac_frame_align #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
    ) u_align (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync_i(sync_i),
        .active_o(active), .last_o(last), .slot_o(slot)
    );

    ac_slot_shift #(.W(SLOT_W)) u_shift (
        .bit_clk(bit_clk), .rst_n(rst_n), .en_i(active),
        .sdi(sdata_i), .word_o(word)
    );

    typedef struct packed {
        logic                 frame_ok;
        logic [NUM_SLOTS-1:0] tags;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic                 tag_stb;
        logic [NUM_SLOTS-1:0] tags_out;
        logic                 cmd_stb;
        logic                 cmd_rd;
        logic [IDX_W-1:0]     cmd_idx;
        logic [DATA_W-1:0]    cmd_wdata;
        logic                 smp_stb;
        logic [CHAN_W-1:0]    smp_chan;
        logic [SAMPLE_W-1:0]  smp_data;
    } dec_t;

    dec_t q, d;

    always_comb begin
        int sl;
        d         = q;
        d.tag_stb = 1'b0;
        d.cmd_stb = 1'b0;
        d.smp_stb = 1'b0;
        sl        = int'(slot);
        if (last) begin
            if (sl == 0) begin
                // tag slot: flag first, then one tag per data slot
                d.frame_ok = word[TAG_W-1];
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    d.tags[i] = word[TAG_W-2-i];
                end
                if (word[TAG_W-1]) begin
                    d.tag_stb  = 1'b1;
                    d.tags_out = d.tags;
                end
            end else if (sl == CMD_ADDR_SLOT) begin
                d.rd  = word[SLOT_W-1];
                d.idx = word[SLOT_W-2 -: IDX_W];
            end else if (sl == CMD_DATA_SLOT) begin
                if (q.frame_ok && q.tags[CMD_ADDR_SLOT-1]) begin
                    if (q.rd) begin
                        d.cmd_stb   = 1'b1;
                        d.cmd_rd    = 1'b1;
                        d.cmd_idx   = q.idx;
                        d.cmd_wdata = '0;
                    end else if (q.tags[CMD_DATA_SLOT-1]) begin
                        d.cmd_stb   = 1'b1;
                        d.cmd_rd    = 1'b0;
                        d.cmd_idx   = q.idx;
                        d.cmd_wdata = word[SLOT_W-1 -: DATA_W];
                    end
                end
            end else begin
                for (int c = 0; c < NUM_PCM_CH; c++) begin
                    if (sl == PCM_SLOT[c] && q.frame_ok && q.tags[PCM_SLOT[c]-1]) begin
                        d.smp_stb  = 1'b1;
                        d.smp_chan = CHAN_W'(c);
                        d.smp_data = word[SLOT_W-1 -: SAMPLE_W];
                    end
                end
            end
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tag_stb_o   = q.tag_stb;
    assign slot_tags_o = q.tags_out;
    assign cmd_stb_o   = q.cmd_stb;
    assign cmd_rd_o    = q.cmd_rd;
    assign cmd_idx_o   = q.cmd_idx;
    assign cmd_wdata_o = q.cmd_wdata;
    assign smp_stb_o   = q.smp_stb;
    assign smp_chan_o  = q.smp_chan;
    assign smp_data_o  = q.smp_data;
endmodule

// File: rtl/aclink_out_deframer_chk.sv
module aclink_out_deframer_chk #(
    parameter int NUM_SLOTS = 12,
    parameter int DATA_W    = 16
) (
    input logic                 bit_clk,
    input logic                 rst_n,
    input logic                 tag_stb_o,
    input logic [NUM_SLOTS-1:0] slot_tags_o,
    input logic                 cmd_stb_o,
    input logic                 cmd_rd_o,
    input logic [DATA_W-1:0]    cmd_wdata_o,
    input logic                 smp_stb_o
);
    AST_TAG_ONE_CYCLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
        tag_stb_o |=> !tag_stb_o); // R11
    AST_CMD_ONE_CYCLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o); // R11
    AST_SMP_ONE_CYCLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
        smp_stb_o |=> !smp_stb_o); // R11
    AST_READ_NO_DATA: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (cmd_stb_o && cmd_rd_o) |-> (cmd_wdata_o == '0)); // R6
    AST_TAGS_HELD: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !tag_stb_o |-> $stable(slot_tags_o)); // R3
    AST_CMD_SMP_APART: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !(cmd_stb_o && smp_stb_o)); // R8
endmodule

bind aclink_out_deframer aclink_out_deframer_chk #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)
) u_chk (
    .bit_clk(bit_clk), .rst_n(rst_n), .tag_stb_o(tag_stb_o),
    .slot_tags_o(slot_tags_o), .cmd_stb_o(cmd_stb_o), .cmd_rd_o(cmd_rd_o),
    .cmd_wdata_o(cmd_wdata_o), .smp_stb_o(smp_stb_o)
);

// File: tb/tb_aclink_out_deframer.sv
`timescale 1ns/1ps
module tb_aclink_out_deframer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        sdata = 1'b0;
    logic        tag_stb, cmd_stb, cmd_rd, smp_stb;
    logic [11:0] slot_tags;
    logic [6:0]  cmd_idx;
    logic [15:0] cmd_wdata;
    logic [1:0]  smp_chan;
    logic [19:0] smp_data;

    int checks = 0;
    int errors = 0;
    int cur_bit = -2;
    bit done = 1'b0;

    always #4 clk = ~clk;

    aclink_out_deframer dut (
        .bit_clk(clk), .rst_n(rst_n), .sync_i(sync), .sdata_i(sdata),
        .tag_stb_o(tag_stb), .slot_tags_o(slot_tags), .cmd_stb_o(cmd_stb),
        .cmd_rd_o(cmd_rd), .cmd_idx_o(cmd_idx), .cmd_wdata_o(cmd_wdata),
        .smp_stb_o(smp_stb), .smp_chan_o(smp_chan), .smp_data_o(smp_data)
    );

    // event log: kind 0 tag, 1 command, 2 sample
    int ev_n = 0;
    int ev_kind [16];
    int ev_pos  [16];
    int ev_a    [16];
    int ev_b    [16];
    int ev_rd   [16];

    task automatic rec(input int k, input int a, input int b, input int r);
        if (ev_n < 16) begin
            ev_kind[ev_n] = k; ev_pos[ev_n] = cur_bit;
            ev_a[ev_n] = a; ev_b[ev_n] = b; ev_rd[ev_n] = r;
        end
        ev_n++;
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (tag_stb) rec(0, int'(slot_tags), 0, 0);
            if (cmd_stb) rec(1, int'(cmd_wdata), int'(cmd_idx), int'(cmd_rd));
            if (smp_stb) rec(2, int'(smp_data), int'(smp_chan), 0);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_ev(input int i, input int k, input int pos, input int a,
                            input int b, input int r, input string req);
        check({req, " kind"}, ev_kind[i], k);
        check({req, " position"}, ev_pos[i], pos);
        check({req, " payload"}, ev_a[i], a);
        check({req, " index/channel"}, ev_b[i], b);
        check({req, " rd flag"}, ev_rd[i], r);
    endtask

    // frame under construction
    logic [19:0]  sv [13];
    logic [255:0] fr;

    task automatic clear_slots();
        for (int s = 0; s < 13; s++) sv[s] = '0;
    endtask

    task automatic build(input logic v, input logic [11:0] tg);
        logic [15:0] t;
        t = '0;
        t[15] = v;
        for (int i = 0; i < 12; i++) t[14-i] = tg[i];
        fr[255:240] = t;
        for (int s = 1; s <= 12; s++) fr[255-(16+20*(s-1)) -: 20] = sv[s];
    endtask

    task automatic drive_bit(input logic s, input logic dbit, input int idx);
        @(posedge clk);
        sync = s; sdata = dbit; cur_bit = idx;
    endtask

    task automatic send_frame(input int nbits);
        ev_n = 0;
        drive_bit(1'b1, 1'b0, -1);
        for (int b = 0; b < nbits; b++) drive_bit(b < 15, fr[255-b], b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b0, 1'b0, -2);
    endtask

    task automatic t_reset();
        #1;
        check("R1 tag_stb", int'(tag_stb), 0);
        check("R1 cmd_stb", int'(cmd_stb), 0);
        check("R1 smp_stb", int'(smp_stb), 0);
        check("R1 slot_tags", int'(slot_tags), 0);
        check("R1 cmd fields", int'({cmd_rd, cmd_idx, cmd_wdata}), 0);
        check("R1 smp fields", int'({smp_chan, smp_data}), 0);
    endtask

    task automatic t_no_sync();
        ev_n = 0;
        for (int i = 0; i < 300; i++) drive_bit(1'b0, ((i % 3) == 0), -2);
        idle(2);
        check("R2 nothing before alignment", ev_n, 0);
    endtask

    task automatic t_full_frame();
        clear_slots();
        sv[1] = {1'b0, 7'h1C, 12'h000};
        sv[2] = {16'hABCD, 4'h0};
        sv[3] = 20'h12345; sv[4] = 20'hFEDCB;
        sv[7] = 20'h80001; sv[8] = 20'h7FFFE;
        sv[5] = 20'hFFFFF; sv[6] = 20'hAAAAA; sv[9] = 20'h55555;
        sv[10] = 20'hFFFFF; sv[11] = 20'h0F0F0; sv[12] = 20'hFFFFF;
        build(1'b1, 12'hFFF);
        send_frame(256);
        idle(2);
        check("R10 R11 event count, unused slots silent", ev_n, 6);
        check_ev(0, 0, 15, 12'hFFF, 0, 0, "R3 tag strobe");
        check_ev(1, 1, 55, 16'hABCD, 7'h1C, 0, "R5 write");
        check_ev(2, 2, 75, 20'h12345, 0, 0, "R8 front left");
        check_ev(3, 2, 95, 20'hFEDCB, 1, 0, "R8 front right");
        check_ev(4, 2, 155, 20'h80001, 2, 0, "R8 surround left");
        check_ev(5, 2, 175, 20'h7FFFE, 3, 0, "R8 surround right");
    endtask

    task automatic t_read();
        clear_slots();
        sv[1] = {1'b1, 7'h26, 12'h000};
        sv[2] = 20'hFFFFF;
        build(1'b1, 12'h003);
        send_frame(256);
        idle(2);
        check("R6 event count", ev_n, 2);
        check_ev(1, 1, 55, 0, 7'h26, 1, "R6 read");
    endtask

    task automatic t_partial_tags();
        clear_slots();
        sv[1] = {1'b0, 7'h02, 12'h000};
        sv[2] = {16'h1234, 4'h0};
        sv[3] = 20'h11111; sv[4] = 20'h22222;
        sv[7] = 20'h33333; sv[8] = 20'h44444;
        build(1'b1, 12'h089);
        send_frame(256);
        idle(2);
        check("R7 R9 event count", ev_n, 3);
        check_ev(0, 0, 15, 12'h089, 0, 0, "R3 partial tags");
        check_ev(1, 2, 95, 20'h22222, 1, 0, "R9 only tagged right");
        check_ev(2, 2, 175, 20'h44444, 3, 0, "R9 only tagged surround right");
    endtask

    task automatic t_invalid_frame();
        clear_slots();
        sv[1] = {1'b0, 7'h10, 12'h000};
        sv[2] = {16'h5A5A, 4'h0};
        sv[3] = 20'h99999; sv[8] = 20'h88888;
        build(1'b0, 12'hFFF);
        send_frame(256);
        idle(2);
        check("R4 no strobes when frame flag clear", ev_n, 0);
        check("R4 slot_tags kept", int'(slot_tags), 12'h089);
    endtask

    task automatic t_realign();
        clear_slots();
        sv[3] = 20'hDEAD0;
        build(1'b1, 12'h004);
        send_frame(60);
        clear_slots();
        sv[1] = {1'b0, 7'h3F, 12'h000};
        sv[2] = {16'hC0DE, 4'h0};
        sv[7] = 20'hBEEF1;
        build(1'b1, 12'h043);
        send_frame(256);
        idle(2);
        check("R2 realigned event count", ev_n, 3);
        check_ev(0, 0, 15, 12'h043, 0, 0, "R2 realigned tags");
        check_ev(1, 1, 55, 16'hC0DE, 7'h3F, 0, "R2 realigned write");
        check_ev(2, 2, 155, 20'hBEEF1, 2, 0, "R2 realigned surround left");
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(posedge clk);
        rst_n = 1'b1;
        t_no_sync();
        t_full_frame();
        t_read();
        t_partial_tags();
        t_invalid_frame();
        t_realign();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule